// File: doc/BRIEF.md
# Binary Scaler with Phase Strobes

The block divides a slow square-wave reference by successive powers of two. An active-low reference line (nominally 102.4 kHz, changing level about every 4.88 us) is sampled in a fast system clock domain. Every high-to-low transition of that line advances a chain of halving stages, so the stages together behave as a binary counter. Stage 1 is the least significant bit and has a half-period of about 10 us. Up to 33 stages can be built.

Each stage also drives two narrow phase strobes. The rise strobe marks the qualifying high half-cycle just before the stage output goes high. The fall strobe marks the qualifying high half-cycle just before it goes low. Stage 1 is qualified by the reference line. Every later stage is qualified by the stage below it. Each stage also drives a separately registered copy of its output for extra fan-out.

A synchronous reset holds every output low. On release, counting resumes from a parameter preset, because the physical chain has no guaranteed power-up value. The system clock must run at least eight times faster than the reference.

Top module: `binary_scaler`

## Requirements
- R1: While `rst` is sampled high at a rising `clk` edge, from that edge on every bit of `stage_out`, `stage_copy`, `strobe_rise` and `strobe_fall` reads 0.
- R2: Each high-to-low transition of `ref_n` advances the count by one, modulo 2^NUM_STAGES. The count appears on `stage_out`, with bit 0 as stage 1. The new value appears after the second `clk` edge following the first edge that samples the low level.
- R3: A low-to-high transition of `ref_n` leaves `stage_out` unchanged.
- R4: `strobe_rise[0]` is 1 exactly when the delayed reference level is high and `stage_out[0]` is 0. The delayed reference level is the `ref_n` value sampled two edges earlier.
- R5: `strobe_fall[0]` is 1 exactly when the delayed reference level is high and `stage_out[0]` is 1.
- R6: `stage_copy` equals `stage_out` on every cycle.
- R7: After `rst` is released, the first edge makes `stage_out` equal PRESET. No count is taken on release, even when `ref_n` is already low.
- R8: After all ones, the next reference high-to-low transition wraps `stage_out` to zero.
- R9: For stage k above 1, bit k-1 of `stage_out` is the qualifier. `strobe_rise[k-1]` is 1 when bit k-2 is 1 and bit k-1 is 0. `strobe_fall[k-1]` is 1 when both bits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the reference rate |
| rst | input | 1 | Synchronous active-high reset |
| ref_n | input | 1 | Active-low reference square wave, asynchronous |
| stage_out | output | NUM_STAGES | Stage outputs; bit 0 is the first halving stage |
| stage_copy | output | NUM_STAGES | Buffered copy of each stage output |
| strobe_rise | output | NUM_STAGES | Per-stage strobe before the output rises |
| strobe_fall | output | NUM_STAGES | Per-stage strobe before the output falls |

## Verification
The bench builds two instances side by side on one reference. The first has six stages and a preset of 58. This reaches the all-ones wrap within a few reference periods and gives carries through every stage boundary, so each stage's qualifier can be checked against the stage below it. The second has one stage and a preset of 1. This covers the degenerate chain in which only the reference qualifies the strobes, and reset release with a nonzero preset. The reference is driven well above 102.4 kHz relative to the bench clock, with both regular and uneven half-periods, while keeping the eightfold clock margin.

// File: rtl/scaler_pkg.sv
package scaler_pkg;

    localparam int MAX_STAGES = 33;

    // Three-flop sampling pipe for the asynchronous reference line.
    typedef struct packed {
        logic meta;
        logic stable;
        logic last;
    } ref_pipe_t;

    function automatic logic high_to_low(input logic older, input logic newer);
        return older & ~newer;
    endfunction

endpackage

// File: rtl/scaler_ref_sync.sv
module scaler_ref_sync
    import scaler_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ref_n,
    output logic fall_edge,
    output logic ref_level
);

    ref_pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d        = pipe_q;
        pipe_d.meta   = ref_n;
        pipe_d.stable = pipe_q.meta;
        pipe_d.last   = pipe_q.stable;
        if (rst) begin
            pipe_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        pipe_q <= pipe_d;
    end

    assign fall_edge = high_to_low(pipe_q.last, pipe_q.stable);
    assign ref_level = pipe_q.last;

    // R2: one reference transition yields a single-cycle advance pulse
    p_single_advance_r2: assert property (@(posedge clk) disable iff (rst)
        fall_edge |=> !fall_edge);

endmodule

// File: rtl/scaler_stage_chain.sv
module scaler_stage_chain #(
    parameter int                    NUM_STAGES = 33,
    parameter logic [NUM_STAGES-1:0] PRESET     = '0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  advance,
    output logic                  live,
    output logic [NUM_STAGES-1:0] stage_out,
    output logic [NUM_STAGES-1:0] stage_copy
);

    typedef struct packed {
        logic [NUM_STAGES-1:0] cnt;
        logic [NUM_STAGES-1:0] dup;
        logic                  run;
    } chain_t;

    chain_t chain_d, chain_q;
    logic [NUM_STAGES-1:0] cnt_next;

    always_comb begin
        cnt_next    = chain_q.cnt + NUM_STAGES'(advance);
        chain_d     = chain_q;
        chain_d.run = 1'b1;
        if (chain_q.run) begin
            chain_d.cnt = cnt_next;
            chain_d.dup = cnt_next;
        end else begin
            chain_d.cnt = PRESET;
            chain_d.dup = PRESET;
        end
        if (rst) begin
            chain_d.cnt = PRESET;
            chain_d.dup = PRESET;
            chain_d.run = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        chain_q <= chain_d;
    end

    assign live       = chain_q.run;
    assign stage_out  = chain_q.run ? chain_q.cnt : '0;
    assign stage_copy = chain_q.run ? chain_q.dup : '0;

    // R2: the count moves by at most one step per clock
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (live && $past(live)) |->
        ((stage_out == $past(stage_out)) ||
         (stage_out == $past(stage_out) + NUM_STAGES'(1))));

    // R6: the buffered bank tracks the main bank
    p_copy_match_r6: assert property (@(posedge clk) disable iff (rst)
        stage_copy == stage_out);

    // R7: first live cycle after reset shows the preset
    p_preset_load_r7: assert property (@(posedge clk) disable iff (rst)
        (live && !$past(live)) |-> (stage_out == PRESET));

endmodule

// File: rtl/scaler_strobe_decode.sv
module scaler_strobe_decode #(
    parameter int NUM_STAGES = 33
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  live,
    input  logic                  ref_level,
    input  logic [NUM_STAGES-1:0] stage_out,
    output logic [NUM_STAGES-1:0] strobe_rise,
    output logic [NUM_STAGES-1:0] strobe_fall
);

    logic [NUM_STAGES-1:0] qual;

    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
        if (k == 0) begin : g_first
            assign qual[k] = ref_level;
        end else begin : g_upper
            assign qual[k] = stage_out[k-1];
        end
        assign strobe_rise[k] = live & qual[k] & ~stage_out[k];
        assign strobe_fall[k] = live & qual[k] &  stage_out[k];
    end

    // R4 R5: the two strobes of a stage are never high together
    p_strobe_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
        (strobe_rise & strobe_fall) == '0);

endmodule

// File: rtl/binary_scaler.sv
module binary_scaler #(
    parameter int                    NUM_STAGES = 33,
    parameter logic [NUM_STAGES-1:0] PRESET     = '0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ref_n,
    output logic [NUM_STAGES-1:0] stage_out,
    output logic [NUM_STAGES-1:0] stage_copy,
    output logic [NUM_STAGES-1:0] strobe_rise,
    output logic [NUM_STAGES-1:0] strobe_fall
);

    logic fall_edge;
    logic ref_level;
    logic live;

    scaler_ref_sync u_sync (
        .clk       (clk),
        .rst       (rst),
        .ref_n     (ref_n),
        .fall_edge (fall_edge),
        .ref_level (ref_level)
    );

    scaler_stage_chain #(
        .NUM_STAGES (NUM_STAGES),
        .PRESET     (PRESET)
    ) u_chain (
        .clk        (clk),
        .rst        (rst),
        .advance    (fall_edge),
        .live       (live),
        .stage_out  (stage_out),
        .stage_copy (stage_copy)
    );

    scaler_strobe_decode #(
        .NUM_STAGES (NUM_STAGES)
    ) u_strobe (
        .clk         (clk),
        .rst         (rst),
        .live        (live),
        .ref_level   (ref_level),
        .stage_out   (stage_out),
        .strobe_rise (strobe_rise),
        .strobe_fall (strobe_fall)
    );

    // R4: stage 1 only rises after a cycle showing its rise strobe
    p_rise_lead_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(stage_out[0]) && $past(live)) |-> $past(strobe_rise[0]));

    // R5: stage 1 only falls after a cycle showing its fall strobe
    p_fall_lead_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(stage_out[0]) && $past(live)) |-> $past(strobe_fall[0]));

    for (genvar k = 1; k < NUM_STAGES; k++) begin : g_carry_chk
        // R9: an upper stage rises only out of its own rise strobe
        p_carry_rise_r9: assert property (@(posedge clk) disable iff (rst)
            ($rose(stage_out[k]) && $past(live)) |-> $past(strobe_rise[k]));
    end

endmodule

// File: tb/binary_scaler_bench.sv
module binary_scaler_bench;

    localparam int          NA = 6;
    localparam logic [5:0]  PA = 6'd58;
    localparam int          NB = 1;
    localparam logic [0:0]  PB = 1'b1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_n = 1'b1;

    always #4 clk = ~clk;

    logic [NA-1:0] a_out, a_copy, a_rise, a_fall;
    logic [NB-1:0] b_out, b_copy, b_rise, b_fall;

    binary_scaler #(.NUM_STAGES(NA), .PRESET(PA)) u_binary_scaler (
        .clk(clk), .rst(rst), .ref_n(ref_n),
        .stage_out(a_out), .stage_copy(a_copy),
        .strobe_rise(a_rise), .strobe_fall(a_fall));

    binary_scaler #(.NUM_STAGES(NB), .PRESET(PB)) u_binary_scaler_one (
        .clk(clk), .rst(rst), .ref_n(ref_n),
        .stage_out(b_out), .stage_copy(b_copy),
        .strobe_rise(b_rise), .strobe_fall(b_fall));

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural model state
    bit hist[$];
    bit valid = 1'b0;
    bit run = 1'b0;
    bit lvl = 1'b0;
    bit wrapped = 1'b0;
    int cnt_a = 0;
    int cnt_b = 0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] strobe_exp(input int cnt, input int n,
                                              input bit level, input bit on,
                                              input bit want_high);
        logic [63:0] r = '0;
        for (int k = 0; k < n; k++) begin
            bit q = (k == 0) ? level : cnt[k-1];
            bit s = cnt[k];
            r[k] = on && q && (s == want_high);
        end
        return r;
    endfunction

    always @(posedge clk) begin
        valid   <= 1'b1;
        wrapped <= 1'b0;
        if (rst) begin
            hist = {1'b0, 1'b0, 1'b0, 1'b0};
            run  = 1'b0;
            cnt_a = int'(PA);
            cnt_b = int'(PB);
        end else begin
            hist.push_front(ref_n);
            void'(hist.pop_back());
            if (hist[3] && !hist[2]) begin
                if (cnt_a == (1 << NA) - 1) wrapped <= 1'b1;
                cnt_a = (cnt_a + 1) % (1 << NA);
                cnt_b = (cnt_b + 1) % (1 << NB);
            end
            run = 1'b1;
        end
        lvl = hist[2];
    end

    always @(negedge clk) begin
        if (valid && !done) begin
            chk(run ? "R2" : "R1", "a stage", 64'(a_out), run ? 64'(cnt_a) : 64'd0);
            chk(run ? "R2" : "R1", "b stage", 64'(b_out), run ? 64'(cnt_b) : 64'd0);
            chk("R6", "a copy", 64'(a_copy), run ? 64'(cnt_a) : 64'd0);
            chk("R6", "b copy", 64'(b_copy), run ? 64'(cnt_b) : 64'd0);
            chk("R4 R9", "a rise", 64'(a_rise), strobe_exp(cnt_a, NA, lvl, run, 1'b0));
            chk("R5 R9", "a fall", 64'(a_fall), strobe_exp(cnt_a, NA, lvl, run, 1'b1));
            chk("R4", "b rise", 64'(b_rise), strobe_exp(cnt_b, NB, lvl, run, 1'b0));
            chk("R5", "b fall", 64'(b_fall), strobe_exp(cnt_b, NB, lvl, run, 1'b1));
            if (wrapped) chk("R8", "a wrap to zero", 64'(a_out), 64'd0);
        end
    end

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        done = 1'b1;
        summary();
    end

    initial begin
        rst = 1'b1;
        ref_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1", "reset a", 64'(a_out | a_rise | a_fall | a_copy), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R7", "preset a", 64'(a_out), 64'(PA));
        chk("R7", "preset b", 64'(b_out), 64'(PB));
        // regular reference, enough edges to wrap the six-stage chain
        for (int i = 0; i < 160; i++) begin
            ref_n = ~ref_n;
            repeat (8) @(negedge clk);
        end
        // reset with the reference held low, release while still low
        ref_n = 1'b0;
        repeat (6) @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "mid-run reset a", 64'(a_out | a_copy), 64'd0);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        chk("R7", "no count on low release", 64'(a_out), 64'(PA));
        // low-to-high transition must not move the count
        ref_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R3", "rising reference ignored", 64'(a_out), 64'(PA));
        chk("R3", "rising reference ignored b", 64'(b_out), 64'(PB));
        // uneven half-periods
        for (int i = 0; i < 300; i++) begin
            ref_n = ~ref_n;
            repeat (4 + (i * 5) % 9) @(negedge clk);
        end
        done = 1'b1;
        summary();
    end

endmodule